// File: doc/BRIEF.md
# Write-Through Data Cache with Two-Stage Store Pipeline

This block is a direct-mapped data cache for a load/store core. Memory is written through on every store. Each line is split into one-word subblocks, and each word has its own valid flag. A store runs in two stages. In the cycle it is accepted, the line tag and the word's valid flag are updated and the store is copied to the write-through port. The data word itself waits in a one-entry pending-store register. It is written into the data array in a later cycle when the array port is free, usually while the next store is being accepted. Every load compares its address with the pending entry and takes the data from it on a match.

A store that finds a different tag in its line takes the line over at once. The tag is rewritten, every other word of the line is marked invalid, and the stored word is marked valid. Memory always holds a current copy, so nothing is lost. A load miss fetches only the one word it needs. Before the fetch starts, the cache waits until the write-through slot and the pending-store register are both empty, so the fetch never returns data older than a store already accepted. If the write-through slot is full and memory refuses it, new stores stall. Loads that hit keep being served.

Top module: `wtc_cache`

## Requirements
- R1: A load that hits raises `rsp_valid` for the cycle right after the cycle in which it is accepted, with the word on `rsp_rdata`, and does not raise `fill_req`.
- R2: A load to the address of the store still waiting in the pending-store register returns that store's data, including a load accepted in the cycle right after the store.
- R3: The word address is split as follows: bits [OFF_W-1:0] select the word, the next IDX_W bits select the line, and the remaining top bits form the tag. An accepted store rewrites the line tag and marks its word valid in that same cycle, so a later load to that address hits.
- R4: A store whose tag equals the line tag leaves the valid flags of the other words in the line unchanged.
- R5: A store whose tag differs from the line tag clears the valid flags of all other words in the line, so a load to any of them, under either tag, misses.
- R6: Every accepted store appears once on the write-through port, in acceptance order, with its address and data. Address and data stay stable while `wt_valid` is high and `wt_ready` is low.
- R7: While the write-through slot is full and `wt_ready` is low, `req_ready` is low for stores and stays high for loads.
- R8: On a load miss, `fill_req` rises only once the write-through slot and the pending-store register are empty. `fill_addr` equals the load address and is held until `fill_valid`. The response follows one cycle after `fill_valid` and carries `fill_data`. The fetched word becomes valid under the rules of R4 and R5.
- R9: After reset no word is valid, `rsp_valid`, `wt_valid` and `fill_req` are low, and `req_ready` is high.
- R10: Every load returns the value of the most recent store to its address, or memory's content if there has been no such store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | DATA_W | Load data |
| wt_valid | output | 1 | Write-through store present |
| wt_addr | output | ADDR_W | Write-through word address |
| wt_data | output | DATA_W | Write-through data |
| wt_ready | input | 1 | Memory takes the write-through store |
| fill_req | output | 1 | One-word fetch request for a load miss |
| fill_addr | output | ADDR_W | Fetch word address |
| fill_valid | input | 1 | Fetch data present |
| fill_data | input | DATA_W | Fetched word |

## Verification
Some rules are checked by assertions on every cycle. These cover: the write-through entry stays stable while stalled, and no store is taken while it is blocked; a fetch starts only once both store buffers are empty, and its address holds until data returns; a store leaves its word valid; and a tag-replacing update leaves exactly one valid word in the line. Other properties need the bench's scenarios against a reference memory: forwarding from the pending-store register on back-to-back accesses, hit versus miss after tag replacement, load progress during a write-through stall, and data correctness across random mixes of store hits, store misses and loads.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  typedef enum logic [1:0] {
    CTL_RUN   = 2'd0,
    CTL_DRAIN = 2'd1,
    CTL_FILL  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
`timescale 1ns/1ps
module wtc_tag_store #(
  parameter int NUM_LINES      = 16,
  parameter int WORDS_PER_LINE = 4,
  parameter int TAG_W          = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [$clog2(NUM_LINES)-1:0]      lk_idx,
  input  logic [TAG_W-1:0]                  lk_tag,
  input  logic [$clog2(WORDS_PER_LINE)-1:0] lk_off,
  output logic                              lk_hit,
  input  logic                              upd_en,
  input  logic [$clog2(NUM_LINES)-1:0]      upd_idx,
  input  logic [TAG_W-1:0]                  upd_tag,
  input  logic [$clog2(WORDS_PER_LINE)-1:0] upd_off
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int OFF_W = $clog2(WORDS_PER_LINE);
  localparam logic [WORDS_PER_LINE-1:0] WORD_ONE = 1;

  logic [TAG_W-1:0]          tag_q [NUM_LINES];
  logic [WORDS_PER_LINE-1:0] vld_q [NUM_LINES];

  assign lk_hit = (tag_q[lk_idx] == lk_tag) && vld_q[lk_idx][lk_off];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q[l] <= '0;
        vld_q[l] <= '0;
      end else if (upd_en && upd_idx == IDX_W'(l)) begin
        if (tag_q[l] == upd_tag) begin
          vld_q[l][upd_off] <= 1'b1;
        end else begin
          tag_q[l] <= upd_tag;
          vld_q[l] <= WORD_ONE << upd_off;
        end
      end
    end
  end

  // Shadow of the last update, used only by the checks below
  logic             chk_en_q;
  logic             chk_repl_q;
  logic [IDX_W-1:0] chk_idx_q;
  logic [OFF_W-1:0] chk_off_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_en_q   <= 1'b0;
      chk_repl_q <= 1'b0;
      chk_idx_q  <= '0;
      chk_off_q  <= '0;
    end else begin
      chk_en_q   <= upd_en;
      chk_repl_q <= upd_en && (tag_q[upd_idx] != upd_tag);
      chk_idx_q  <= upd_idx;
      chk_off_q  <= upd_off;
    end
  end

  AST_UPD_WORD_VALID: assert property (@(posedge clk) disable iff (rst)
    chk_en_q |-> vld_q[chk_idx_q][chk_off_q]); // R3
  AST_REPLACE_SINGLE_WORD: assert property (@(posedge clk) disable iff (rst)
    chk_repl_q |-> ($countones(vld_q[chk_idx_q]) == 1)); // R5
endmodule

// File: rtl/wtc_data_ram.sv
`timescale 1ns/1ps
module wtc_data_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wtc_store_pipe.sv
`timescale 1ns/1ps
module wtc_store_pipe #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_acc,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              drain_en,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_fwd,
  output logic              dwb_valid,
  output logic [SLOT_W-1:0] dwb_slot,
  output logic [DATA_W-1:0] dwb_data,
  output logic              wt_valid,
  output logic [ADDR_W-1:0] wt_addr,
  output logic [DATA_W-1:0] wt_data,
  input  logic              wt_ready,
  output logic              wt_free
);
  logic              dwb_valid_q;
  logic [ADDR_W-1:0] dwb_addr_q;
  logic [DATA_W-1:0] dwb_data_q;
  logic              wt_valid_q;
  logic [ADDR_W-1:0] wt_addr_q;
  logic [DATA_W-1:0] wt_data_q;

  // Pending data-array update: loaded by a store, emptied by a drain
  always_ff @(posedge clk) begin
    if (rst) begin
      dwb_valid_q <= 1'b0;
    end else if (st_acc) begin
      dwb_valid_q <= 1'b1;
    end else if (drain_en) begin
      dwb_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (st_acc) begin
      dwb_addr_q <= st_addr;
      dwb_data_q <= st_data;
    end
  end

  // Write-through slot
  always_ff @(posedge clk) begin
    if (rst) begin
      wt_valid_q <= 1'b0;
    end else if (st_acc) begin
      wt_valid_q <= 1'b1;
    end else if (wt_ready) begin
      wt_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (st_acc) begin
      wt_addr_q <= st_addr;
      wt_data_q <= st_data;
    end
  end

  assign wt_free   = !wt_valid_q || wt_ready;
  assign lk_fwd    = dwb_valid_q && (dwb_addr_q == lk_addr);
  assign dwb_valid = dwb_valid_q;
  assign dwb_slot  = dwb_addr_q[SLOT_W-1:0];
  assign dwb_data  = dwb_data_q;
  assign wt_valid  = wt_valid_q;
  assign wt_addr   = wt_addr_q;
  assign wt_data   = wt_data_q;

  AST_WT_STABLE: assert property (@(posedge clk) disable iff (rst)
    wt_valid_q && !wt_ready |=> wt_valid_q && $stable(wt_addr_q) && $stable(wt_data_q)); // R6
  AST_NO_STORE_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    wt_valid_q && !wt_ready |-> !st_acc); // R7
endmodule

// File: rtl/wtc_cache.sv
`timescale 1ns/1ps
module wtc_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int DATA_W         = 32,
  parameter int WORDS_PER_LINE = 4,
  parameter int NUM_LINES      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wt_valid,
  output logic [ADDR_W-1:0] wt_addr,
  output logic [DATA_W-1:0] wt_data,
  input  logic              wt_ready,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int OFF_W  = $clog2(WORDS_PER_LINE);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int SLOT_W = OFF_W + IDX_W;
  localparam int TAG_W  = ADDR_W - SLOT_W;
  localparam int DEPTH  = NUM_LINES * WORDS_PER_LINE;

  ctl_state_e        state_q;
  logic [ADDR_W-1:0] miss_addr_q;

  logic              wt_free, dwb_valid, ld_fwd, tag_hit;
  logic [SLOT_W-1:0] dwb_slot;
  logic [DATA_W-1:0] dwb_data;
  logic              ld_acc, st_acc, ld_hit, drain_en, fill_done;

  logic              upd_en;
  logic [ADDR_W-1:0] upd_addr;
  logic              ram_we;
  logic [SLOT_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  logic              rsp_valid_q, rsp_fwd_q;
  logic [DATA_W-1:0] rsp_hold_q;

  assign req_ready = (state_q == CTL_RUN) && (!req_write || wt_free);
  assign ld_acc    = req_valid && !req_write && req_ready;
  assign st_acc    = req_valid &&  req_write && req_ready;
  assign ld_hit    = tag_hit || ld_fwd;
  assign fill_done = (state_q == CTL_FILL) && fill_valid;
  // The array port is free for the pending store whenever no load reads it
  assign drain_en  = dwb_valid && !ld_acc;

  assign upd_en   = st_acc || fill_done;
  assign upd_addr = fill_done ? miss_addr_q : req_addr;

  assign ram_we    = fill_done || drain_en;
  assign ram_waddr = fill_done ? miss_addr_q[SLOT_W-1:0] : dwb_slot;
  assign ram_wdata = fill_done ? fill_data : dwb_data;

  wtc_tag_store #(
    .NUM_LINES      (NUM_LINES),
    .WORDS_PER_LINE (WORDS_PER_LINE),
    .TAG_W          (TAG_W)
  ) u_tags (
    .clk     (clk),
    .rst     (rst),
    .lk_idx  (req_addr[OFF_W +: IDX_W]),
    .lk_tag  (req_addr[ADDR_W-1 -: TAG_W]),
    .lk_off  (req_addr[OFF_W-1:0]),
    .lk_hit  (tag_hit),
    .upd_en  (upd_en),
    .upd_idx (upd_addr[OFF_W +: IDX_W]),
    .upd_tag (upd_addr[ADDR_W-1 -: TAG_W]),
    .upd_off (upd_addr[OFF_W-1:0])
  );

  wtc_data_ram #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ld_acc),
    .raddr (req_addr[SLOT_W-1:0]),
    .rdata (ram_rdata)
  );

  wtc_store_pipe #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SLOT_W (SLOT_W)
  ) u_stp (
    .clk       (clk),
    .rst       (rst),
    .st_acc    (st_acc),
    .st_addr   (req_addr),
    .st_data   (req_wdata),
    .drain_en  (drain_en),
    .lk_addr   (req_addr),
    .lk_fwd    (ld_fwd),
    .dwb_valid (dwb_valid),
    .dwb_slot  (dwb_slot),
    .dwb_data  (dwb_data),
    .wt_valid  (wt_valid),
    .wt_addr   (wt_addr),
    .wt_data   (wt_data),
    .wt_ready  (wt_ready),
    .wt_free   (wt_free)
  );

  // Miss control: wait for both store buffers to empty, then fetch one word
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CTL_RUN;
    end else begin
      case (state_q)
        CTL_RUN:   if (ld_acc && !ld_hit) state_q <= CTL_DRAIN;
        CTL_DRAIN: if (!wt_valid && !dwb_valid) state_q <= CTL_FILL;
        CTL_FILL:  if (fill_valid) state_q <= CTL_RUN;
        default:   state_q <= CTL_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ld_acc && !ld_hit) miss_addr_q <= req_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_fwd_q   <= 1'b0;
    end else begin
      rsp_valid_q <= (ld_acc && ld_hit) || fill_done;
      if (ld_acc) begin
        rsp_fwd_q <= ld_fwd;
      end else if (fill_done) begin
        rsp_fwd_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld_acc) begin
      rsp_hold_q <= dwb_data;
    end else if (fill_done) begin
      rsp_hold_q <= fill_data;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_fwd_q ? rsp_hold_q : ram_rdata;
  assign fill_req  = (state_q == CTL_FILL);
  assign fill_addr = miss_addr_q;

  AST_FILL_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> !wt_valid && !dwb_valid); // R8
  AST_FILL_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    fill_req && !fill_valid |=> fill_req && $stable(fill_addr)); // R8
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(ld_acc) || $past(fill_done)); // R1
  AST_NO_REQ_DURING_MISS: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> !req_ready); // R8
endmodule

// File: tb/wtc_cache_tb.sv
`timescale 1ns/1ps
module wtc_cache_tb;
  localparam int AW  = 10;
  localparam int DW  = 32;
  localparam int WPL = 4;
  localparam int NL  = 16;
  localparam int OW  = 2;
  localparam int IW  = 4;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          wt_valid;
  logic [AW-1:0] wt_addr;
  logic [DW-1:0] wt_data;
  logic          wt_ready = 1'b0;
  logic          fill_req;
  logic [AW-1:0] fill_addr;
  logic          fill_valid = 1'b0;
  logic [DW-1:0] fill_data  = '0;

  always #2 clk = ~clk;

  wtc_cache #(.ADDR_W(AW), .DATA_W(DW), .WORDS_PER_LINE(WPL), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wt_valid(wt_valid),
    .wt_addr(wt_addr), .wt_data(wt_data), .wt_ready(wt_ready),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
    .fill_data(fill_data)
  );

  int n_checks = 0;
  int n_fails  = 0;

  logic [DW-1:0] ref_mem   [MEMN];
  logic [DW-1:0] mem_model [MEMN];
  logic [AW-1:0] q_addr [4096];
  logic [DW-1:0] q_data [4096];
  logic [11:0]   q_wr = '0;
  logic [11:0]   q_rd = '0;
  logic [AW-IW-OW-1:0] m_tag [NL];
  logic [WPL-1:0]      m_vld [NL];
  bit            stall_force = 1'b0;
  logic [AW-1:0] fill_seen_addr = '0;
  int            fcnt = 0;

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int t, input int i, input int o);
    return AW'((t << (IW + OW)) | (i << OW) | o);
  endfunction

  function automatic bit m_hit(input logic [AW-1:0] a);
    return (m_tag[a[OW +: IW]] == a[AW-1:OW+IW]) && m_vld[a[OW +: IW]][a[OW-1:0]];
  endfunction

  task automatic m_upd(input logic [AW-1:0] a);
    if (m_tag[a[OW +: IW]] == a[AW-1:OW+IW]) begin
      m_vld[a[OW +: IW]][a[OW-1:0]] = 1'b1;
    end else begin
      m_tag[a[OW +: IW]] = a[AW-1:OW+IW];
      m_vld[a[OW +: IW]] = '0;
      m_vld[a[OW +: IW]][a[OW-1:0]] = 1'b1;
    end
  endtask

  // Memory side: write-through acceptor
  always @(posedge clk) begin
    #1;
    wt_ready = stall_force ? 1'b0 : (($urandom % 4) != 0);
  end

  // Write-through monitor (handshake completes at the next rising edge)
  always @(negedge clk) begin
    if (!rst && wt_valid && wt_ready) begin
      chk(q_rd != q_wr, "R6 unexpected write-through", DW'(wt_addr), 0);
      chk(wt_addr == q_addr[q_rd], "R6 write-through address", DW'(wt_addr), DW'(q_addr[q_rd]));
      chk(wt_data == q_data[q_rd], "R6 write-through data", wt_data, q_data[q_rd]);
      mem_model[wt_addr] = wt_data;
      q_rd = q_rd + 1'b1;
    end
  end

  // Memory side: fetch responder with two cycles of latency
  always @(negedge clk) begin
    if (fill_valid) begin
      fill_valid = 1'b0;
    end else if (!rst && fill_req) begin
      if (fcnt == 2) begin
        fill_seen_addr = fill_addr;
        fill_data  = mem_model[fill_addr];
        fill_valid = 1'b1;
        fcnt = 0;
      end else begin
        fcnt++;
      end
    end
  end

  task automatic st(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    ref_mem[a] = d;
    q_addr[q_wr] = a; q_data[q_wr] = d; q_wr = q_wr + 1'b1;
    m_upd(a);
  endtask

  task automatic ld(input logic [AW-1:0] a, input string rq);
    bit            exp_hit, saw_fill;
    int            lat;
    logic [DW-1:0] exp;
    exp_hit = m_hit(a);
    exp = ref_mem[a];
    saw_fill = 1'b0;
    lat = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    do begin
      @(negedge clk);
      lat++;
      if (fill_req) saw_fill = 1'b1;
    end while (!rsp_valid);
    chk(rsp_rdata == exp, {rq, " load data"}, rsp_rdata, exp);
    chk(saw_fill == !exp_hit, {rq, " hit/miss"}, DW'(saw_fill), DW'(!exp_hit));
    if (exp_hit) begin
      chk(lat == 1, "R1 hit latency", DW'(lat), 1);
    end else begin
      chk(fill_seen_addr == a, "R8 fetch address", DW'(fill_seen_addr), DW'(a));
      m_upd(a);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < MEMN; i++) begin
      ref_mem[i]   = DW'(i * 7 + 3);
      mem_model[i] = DW'(i * 7 + 3);
    end
    for (int i = 0; i < NL; i++) begin
      m_tag[i] = '0;
      m_vld[i] = '0;
    end
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 req_ready after reset", DW'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R9 rsp_valid after reset", DW'(rsp_valid), 0);
    chk(wt_valid == 1'b0, "R9 wt_valid after reset", DW'(wt_valid), 0);
    chk(fill_req == 1'b0, "R9 fill_req after reset", DW'(fill_req), 0);
    ld(mk(0, 1, 0), "R9");
    ld(mk(0, 1, 0), "R1");
    ld(mk(3, 2, 3), "R8");

    // Store then load right away: served from the pending entry
    st(mk(2, 3, 1), 32'hA1A1_0001);
    ld(mk(2, 3, 1), "R2");
    ld(mk(2, 3, 1), "R3");
    // Same-tag store keeps the other word valid
    st(mk(2, 3, 2), 32'hA2A2_0002);
    ld(mk(2, 3, 1), "R4");
    ld(mk(2, 3, 2), "R4");
    // Different tag takes the line over
    st(mk(5, 3, 0), 32'hB0B0_0000);
    ld(mk(5, 3, 0), "R3");
    ld(mk(2, 3, 2), "R5");
    ld(mk(5, 3, 3), "R5");
    // Two stores, then a load of the first (already drained)
    st(mk(1, 7, 0), 32'hC0C0_0000);
    st(mk(1, 7, 1), 32'hC1C1_0001);
    ld(mk(1, 7, 0), "R2");
    ld(mk(1, 7, 1), "R2");

    // Write-through stall: stores blocked, loads still served
    while (wt_valid) @(negedge clk);
    stall_force = 1'b1;
    @(negedge clk);
    st(mk(1, 9, 2), 32'hD7D7_0007);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = mk(1, 9, 3); req_wdata = 32'hD8D8_0008;
    #1;
    chk(req_ready == 1'b0, "R7 store blocked", DW'(req_ready), 0);
    req_write = 1'b0; req_addr = mk(1, 9, 2);
    #1;
    chk(req_ready == 1'b1, "R7 load allowed", DW'(req_ready), 1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R7 load response during stall", DW'(rsp_valid), 1);
    chk(rsp_rdata == 32'hD7D7_0007, "R7 load data during stall", rsp_rdata, 32'hD7D7_0007);
    chk(wt_valid == 1'b1, "R6 entry held while stalled", DW'(wt_valid), 1);
    stall_force = 1'b0;
    st(mk(1, 9, 3), 32'hD8D8_0008);
    ld(mk(1, 9, 3), "R6");

    // Random mix over a small footprint: hits, tag conflicts, back-to-back
    for (int k = 0; k < 2000; k++) begin
      logic [AW-1:0] a;
      a = mk($urandom % 4, $urandom % 4, $urandom % WPL);
      if (($urandom % 2) == 0) st(a, $urandom);
      else ld(a, "R10");
    end

    stall_force = 1'b0;
    repeat (30) @(negedge clk);
    chk(q_rd == q_wr, "R6 all stores written through", DW'(q_rd), DW'(q_wr));
    chk(wt_valid == 1'b0, "R6 write-through slot empty", DW'(wt_valid), 0);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule